// File: doc/BRIEF.md
# Three-Channel Event Timer Bank

This block holds three independent 16-bit timers behind a small word-addressed register port. Each timer keeps a count, a compare value and a control/status word. On every enabled clock tick the count advances. It returns to zero either when it matches the compare value or when it passes full scale, depending on the control word. A match or a full-scale wrap can raise a one-cycle interrupt pulse. The pulse can be limited to the first qualifying event after the control word is written, or allowed on every event. Three sticky status bits record what has happened. Two of them clear when software reads the control word.

Each timer has its own set of tick sources. Timer 0 can count a pixel-rate tick, and timer 1 can count a line-rate tick. Timer 2 can count a system tick divided by eight by an internal prescaler, and it has a halt bit. All three default to the system tick. The pulses on `irq[0]`, `irq[1]` and `irq[2]` are meant for bits 4, 5 and 6 of a shared pending word in the interrupt controller outside this block.

The register port has no data stream, so it has no valid/ready pair. A strobe (`bus_en`) with a direction bit (`bus_we`) completes an access in its own cycle and never stalls. `bus_rdata` is combinational from `bus_addr` and always shows the addressed register. A read side effect happens at the clock edge that ends a read strobe.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, control word and compare value reads 0, `irq` is low, and every timer takes the system tick as its source.
- R2: Byte address bits [5:4] pick the timer (0 to 2) and bits [3:2] pick the register: 0 is the count, 1 is the control word, 2 is the compare value. Any other combination reads 0, and a write to it changes nothing.
- R3: On a tick, control bit 3 set with count equal to compare sends the count to 0. Otherwise a count of 0xFFFF wraps to 0, and any other count adds 1. A tick with count equal to compare is a match event whether or not bit 3 is set. A wrap from 0xFFFF that is not a match-wrap is an overflow event.
- R4: Writing the control word stores write-data bits [9:0] and makes bits [15:10] read 0. It also zeroes the count, re-arms the one-shot latch, and causes the tick of that cycle to be ignored.
- R5: A count write keeps the low 16 bits of write data and takes the place of that cycle's tick. A compare write keeps the low 16 bits and leaves the count as the tick makes it.
- R6: A match event sets control bit 11, an overflow event sets bit 12, and either sets bit 10. Bit 10 stays set until the next control write. A read of the control word returns its value and then clears bits 11 and 12. An event in the same cycle sets them again.
- R7: The cycle after a match event with control bit 4 set, or an overflow event with bit 5 set, `irq[n]` is high for exactly one cycle.
- R8: With control bit 6 clear, only the first qualifying event after a control write pulses `irq[n]`. With bit 6 set, every qualifying event pulses it.
- R9: Control bit 8 switches timer 0 to `pix_tick` and timer 1 to `line_tick`. Control bit 9 switches timer 2 to the prescaled tick.
- R10: The prescaled tick is active on every eighth `sys_tick` counted since reset.
- R11: Control bit 0 of timer 2 stops its count. Register writes to timer 2 still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data; bits above 15 are discarded |
| bus_rdata | output | 16 | Addressed register, combinational |
| sys_tick | input | 1 | System-rate count enable |
| pix_tick | input | 1 | Pixel-rate count enable |
| line_tick | input | 1 | Line-rate count enable |
| irq | output | 3 | One-cycle interrupt pulse per timer |

## Verification
The bench builds the block with its defaults: 16-bit counters, a 32-bit write bus, a 6-bit address and a prescale divide of 8. The 32-bit write bus lets the bench write values above 0xFFFF and confirm they are truncated. Because the count can be preloaded, an overflow is a handful of ticks away, so full-scale wraps happen often in both directed and random traffic. The divide of 8 makes any 40-tick window hold exactly five prescaled ticks, whatever phase the prescaler is in, which keeps the timer 2 source check free of history. A behavioural model runs beside the design and is compared on every cycle under random bus traffic and random tick patterns.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NUM_TMR = 3;

  // control word bit positions
  localparam int MB_STOP   = 0;
  localparam int MB_WRAP   = 3;
  localparam int MB_IE_TGT = 4;
  localparam int MB_IE_OVF = 5;
  localparam int MB_REPEAT = 6;
  localparam int MB_ALT    = 8;
  localparam int MB_DIV    = 9;
  localparam int MB_ANY    = 10;
  localparam int MB_HIT    = 11;
  localparam int MB_OVF    = 12;

  typedef enum logic [1:0] {
    RS_CNT  = 2'd0,
    RS_MODE = 2'd1,
    RS_TGT  = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wr_cnt;
    logic wr_mode;
    logic wr_tgt;
    logic rd_mode;
  } tmr_acc_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_tick,
  output logic pre_tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  assign pre_tick = sys_tick && (ph_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (sys_tick) begin
      ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NT = 3,
  parameter int AW = 6,
  parameter int CW = 16
) (
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [AW-3:0]           word_addr,
  input  logic [NT-1:0][CW-1:0]   cnt_all,
  input  logic [NT-1:0][CW-1:0]   mode_all,
  input  logic [NT-1:0][CW-1:0]   tgt_all,
  output tmr_acc_t [NT-1:0]       acc,
  output logic [CW-1:0]           rdata
);
  localparam int TW = AW - 4;

  logic [TW-1:0] tsel;
  reg_sel_e      rsel;

  assign tsel = word_addr[AW-3:2];
  assign rsel = reg_sel_e'(word_addr[1:0]);

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      logic hit;
      hit = bus_en && (tsel == TW'(i));
      acc[i] = '0;
      case (rsel)
        RS_CNT:  acc[i].wr_cnt  = hit && bus_we;
        RS_MODE: begin
          acc[i].wr_mode = hit && bus_we;
          acc[i].rd_mode = hit && !bus_we;
        end
        RS_TGT:  acc[i].wr_tgt  = hit && bus_we;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NT; i++) begin
      if (tsel == TW'(i)) begin
        case (rsel)
          RS_CNT:  rdata = cnt_all[i];
          RS_MODE: rdata = mode_all[i];
          RS_TGT:  rdata = tgt_all[i];
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  tmr_acc_t      acc,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mode,
  output logic [CW-1:0] tgt,
  output logic          irq
);
  localparam logic [CW-1:0] WMASK = CW'((1 << MB_ANY) - 1);

  logic [CW-1:0] cnt_q, mode_q, tgt_q, mode_nxt;
  logic          fired_q, irq_q;
  logic          adv, match, full, wrap_t, ev_tgt, ev_ovf, want, fire;

  always_comb begin
    adv    = tick && !acc.wr_cnt && !acc.wr_mode;
    match  = (cnt_q == tgt_q);
    full   = &cnt_q;
    wrap_t = mode_q[MB_WRAP] && match;
    ev_tgt = adv && match;
    ev_ovf = adv && full && !wrap_t;
    want   = (ev_tgt && mode_q[MB_IE_TGT]) || (ev_ovf && mode_q[MB_IE_OVF]);
    fire   = want && (mode_q[MB_REPEAT] || !fired_q);

    mode_nxt = mode_q;
    if (acc.rd_mode) begin
      mode_nxt[MB_HIT] = 1'b0;
      mode_nxt[MB_OVF] = 1'b0;
    end
    if (ev_tgt) mode_nxt[MB_HIT] = 1'b1;
    if (ev_ovf) mode_nxt[MB_OVF] = 1'b1;
    if (ev_tgt || ev_ovf) mode_nxt[MB_ANY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= '0;
      tgt_q   <= '0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (acc.wr_mode) begin
      mode_q  <= wdata & WMASK;
      cnt_q   <= '0;
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (acc.wr_cnt) cnt_q <= wdata;
      else if (adv)   cnt_q <= wrap_t ? '0 : cnt_q + 1'b1;
      if (acc.wr_tgt) tgt_q <= wdata;
      mode_q <= mode_nxt;
      irq_q  <= fire;
      if (fire) fired_q <= 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign mode = mode_q;
  assign tgt  = tgt_q;
  assign irq  = irq_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int CW        = 16,
  parameter int DW        = 32,
  parameter int AW        = 6,
  parameter int PRESC_DIV = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          sys_tick,
  input  logic          pix_tick,
  input  logic          line_tick,
  output logic [2:0]    irq
);
  localparam int NT = NUM_TMR;

  logic [NT-1:0][CW-1:0] cnt_all, mode_all, tgt_all;
  tmr_acc_t [NT-1:0]     acc;
  logic                  pre_tick;
  logic                  side_unused;

  assign side_unused = ^{bus_wdata[DW-1:CW], bus_addr[1:0]};

  tmr_prescale #(.DIV(PRESC_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_tick (sys_tick),
    .pre_tick (pre_tick)
  );

  tmr_regif #(.NT(NT), .AW(AW), .CW(CW)) u_regif (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .word_addr (bus_addr[AW-1:2]),
    .cnt_all   (cnt_all),
    .mode_all  (mode_all),
    .tgt_all   (tgt_all),
    .acc       (acc),
    .rdata     (bus_rdata)
  );

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic tick;
    if (i == 0) begin : g_src
      assign tick = mode_all[i][MB_ALT] ? pix_tick : sys_tick;
    end else if (i == 1) begin : g_src
      assign tick = mode_all[i][MB_ALT] ? line_tick : sys_tick;
    end else begin : g_src
      assign tick = !mode_all[i][MB_STOP] &&
                    (mode_all[i][MB_DIV] ? pre_tick : sys_tick);
    end

    tmr_core #(.CW(CW)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .acc   (acc[i]),
      .wdata (bus_wdata[CW-1:0]),
      .cnt   (cnt_all[i]),
      .mode  (mode_all[i]),
      .tgt   (tgt_all[i]),
      .irq   (irq[i])
    );
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int CW = 16,
  parameter int AW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [AW-3:0]        waddr,
  input logic [CW-1:0]        wdata,
  input logic [2:0]           irq,
  input logic [2:0][CW-1:0]   cnt_all,
  input logic [2:0][CW-1:0]   mode_all,
  input logic [2:0][CW-1:0]   tgt_all
);
  logic chk_unused;
  assign chk_unused = ^{mode_all, cnt_all};

  for (genvar i = 0; i < 3; i++) begin : g_t
    localparam logic [AW-3:0] A_MODE = (AW-2)'(i * 4 + 1);
    localparam logic [AW-3:0] A_TGT  = (AW-2)'(i * 4 + 2);

    // R4: control write zeroes the count and status bits
    p_mode_wr_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && waddr == A_MODE) |=>
        (cnt_all[i] == '0 && mode_all[i][12:10] == 3'b000));

    // R5: compare write lands with the low data bits
    p_tgt_wr_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && waddr == A_TGT) |=> (tgt_all[i] == $past(wdata)));

    // R7: a pulse needs an enabled event source in the previous cycle
    p_irq_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ($past(mode_all[i][4]) || $past(mode_all[i][5])));

    // R6: a pulse is always accompanied by the any-event flag
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> mode_all[i][10]);
  end

  // R11: a halted timer 2 holds its count when no write arrives
  p_stop_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_all[2][0] && !(bus_en && bus_we)) |=> $stable(cnt_all[2]));
endmodule

bind tmr_bank tmr_bank_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .waddr    (bus_addr[AW-1:2]),
  .wdata    (bus_wdata[CW-1:0]),
  .irq      (irq),
  .cnt_all  (cnt_all),
  .mode_all (mode_all),
  .tgt_all  (tgt_all)
);

// File: tb/tmr_bank_test.sv
`timescale 1ns/1ps
module tmr_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sys_tick = 1'b0, pix_tick = 1'b0, line_tick = 1'b0;
  logic [2:0]  irq;

  int total = 0, bad = 0, cyc_n = 0, irqc = 0;

  tmr_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_tick(sys_tick), .pix_tick(pix_tick), .line_tick(line_tick), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_cnt[3], m_mode[3], m_tgt[3], m_pc;
  bit m_fired[3], m_irq[3];

  function automatic int mread(input logic [5:0] a);
    int t, r;
    t = a[5:4]; r = a[3:2];
    if (t > 2) return 0;
    if (r == 0) return m_cnt[t];
    if (r == 1) return m_mode[t];
    if (r == 2) return m_tgt[t];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0;
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_mode[i] = 0; m_tgt[i] = 0; m_fired[i] = 0; m_irq[i] = 0;
      end
    end else begin
      bit pt;
      int t, r, wd;
      pt = sys_tick && (m_pc == 7);
      if (sys_tick) m_pc = (m_pc == 7) ? 0 : m_pc + 1;
      t = bus_addr[5:4]; r = bus_addr[3:2];
      wd = bus_wdata[15:0];
      for (int i = 0; i < 3; i++) begin
        bit tk, wr, rdm, tev, oev, hit, wrp;
        int md;
        md = m_mode[i];
        if (i == 0)      tk = md[8] ? pix_tick : sys_tick;
        else if (i == 1) tk = md[8] ? line_tick : sys_tick;
        else             tk = md[0] ? 1'b0 : (md[9] ? pt : sys_tick);
        wr  = bus_en && bus_we && (t == i);
        rdm = bus_en && !bus_we && (t == i) && (r == 1);
        m_irq[i] = 0;
        tev = 0; oev = 0;
        if (wr && r == 1) begin
          m_mode[i] = wd & 16'h03FF; m_cnt[i] = 0; m_fired[i] = 0;
        end else begin
          if (wr && r == 0) m_cnt[i] = wd;
          else if (tk) begin
            hit = (m_cnt[i] == m_tgt[i]);
            wrp = hit && md[3];
            tev = hit;
            oev = !wrp && (m_cnt[i] == 16'hFFFF);
            m_cnt[i] = wrp ? 0 : ((m_cnt[i] + 1) & 16'hFFFF);
          end
          if (wr && r == 2) m_tgt[i] = wd;
          if (rdm) m_mode[i] = m_mode[i] & ~16'h1800;
          if (tev) m_mode[i] = m_mode[i] | 16'h0C00;
          if (oev) m_mode[i] = m_mode[i] | 16'h1400;
          if (((tev && md[4]) || (oev && md[5])) && (md[6] || !m_fired[i])) begin
            m_irq[i] = 1; m_fired[i] = 1;
          end
        end
      end
    end
  end

  // per-cycle comparison, before new stimulus is applied
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd;
      string tg;
      exp_rd = mread(bus_addr);
      case (bus_addr[3:2])
        2'd0: tg = "R3 count";
        2'd1: tg = "R6 control";
        2'd2: tg = "R5 compare";
        default: tg = "R2 unmapped";
      endcase
      chk(bus_rdata == exp_rd[15:0], tg, bus_rdata, exp_rd);
      chk(irq == {m_irq[2], m_irq[1], m_irq[0]}, "R7 irq", irq,
          {m_irq[2], m_irq[1], m_irq[0]});
    end
    if (irq[0]) irqc++;
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 200000) begin
      chk(0, "watchdog", cyc_n, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic slot();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    slot();
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    sys_tick = 0; pix_tick = 0; line_tick = 0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    slot();
    bus_en = 1; bus_we = 0; bus_addr = a;
    sys_tick = 0; pix_tick = 0; line_tick = 0;
    #2 v = bus_rdata;
  endtask

  task automatic run(input int n, input bit s);
    for (int k = 0; k < n; k++) begin
      slot();
      bus_en = 0; bus_we = 0;
      sys_tick = s; pix_tick = 0; line_tick = 0;
    end
  endtask

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset values
    chk(irq == 3'b000, "R1 irq", irq, 0);
    for (int t = 0; t < 3; t++)
      for (int r = 0; r < 3; r++) begin
        rd(6'(t * 16 + r * 4), v);
        chk(v == 0, "R1 reset reg", v, 0);
      end

    // R2: unmapped slots read zero, writes there change nothing
    rd(6'h0C, v); chk(v == 0, "R2 slot3", v, 0);
    rd(6'h30, v); chk(v == 0, "R2 timer3", v, 0);
    wr(6'h0C, 32'h1234);
    wr(6'h3C, 32'hFFFF);
    rd(6'h00, v); chk(v == 0, "R2 cnt untouched", v, 0);
    rd(6'h04, v); chk(v == 0, "R2 mode untouched", v, 0);
    rd(6'h08, v); chk(v == 0, "R2 tgt untouched", v, 0);

    // R5: truncation, compare write keeps count
    wr(6'h00, 32'h1ABCD);
    rd(6'h00, v); chk(v == 16'hABCD, "R5 count trunc", v, 16'hABCD);
    wr(6'h08, 32'h10007);
    rd(6'h08, v); chk(v == 7, "R5 compare trunc", v, 7);
    rd(6'h00, v); chk(v == 16'hABCD, "R5 count kept", v, 16'hABCD);

    // R4: control write masks and zeroes the count
    wr(6'h10, 32'h0042);
    wr(6'h14, 32'hFFFF);
    rd(6'h14, v); chk(v == 16'h03FF, "R4 mode mask", v, 16'h03FF);
    rd(6'h10, v); chk(v == 0, "R4 count zero", v, 0);

    // R8 repeat, R3 match wrap
    wr(6'h04, 32'h0058); wr(6'h08, 32'h3);
    run(1, 0); irqc = 0;
    run(12, 1); run(3, 0);
    chk(irqc == 3, "R8 repeat pulses", irqc, 3);
    rd(6'h00, v); chk(v == 0, "R3 wrap at match", v, 0);
    rd(6'h04, v); chk(v == 16'h0C58, "R6 flags set", v, 16'h0C58);
    rd(6'h04, v); chk(v == 16'h0458, "R6 read clears", v, 16'h0458);

    // R8 one-shot
    wr(6'h04, 32'h0018);
    run(1, 0); irqc = 0;
    run(12, 1); run(3, 0);
    chk(irqc == 1, "R8 one-shot pulse", irqc, 1);

    // R7 overflow interrupt, R3 full-scale wrap
    wr(6'h04, 32'h0020); wr(6'h00, 32'hFFFD);
    run(1, 0); irqc = 0;
    run(4, 1); run(2, 0);
    chk(irqc == 1, "R7 overflow pulse", irqc, 1);
    rd(6'h00, v); chk(v == 1, "R3 past full scale", v, 1);
    rd(6'h04, v); chk(v == 16'h1420, "R6 overflow flag", v, 16'h1420);

    // R7 no pulse without enable
    wr(6'h04, 32'h0008); wr(6'h08, 32'h2);
    run(1, 0); irqc = 0;
    run(6, 1); run(2, 0);
    chk(irqc == 0, "R7 disabled", irqc, 0);
    rd(6'h04, v); chk(v == 16'h0C08, "R6 match flag", v, 16'h0C08);

    // R9 tick sources
    wr(6'h04, 32'h0100); wr(6'h14, 32'h0100); wr(6'h24, 32'h0000);
    for (int k = 0; k < 10; k++) begin
      slot();
      bus_en = 0; sys_tick = 1; pix_tick = (k % 2 == 0); line_tick = (k < 3);
    end
    run(1, 0);
    rd(6'h00, v); chk(v == 5, "R9 pixel source", v, 5);
    rd(6'h10, v); chk(v == 3, "R9 line source", v, 3);
    rd(6'h20, v); chk(v == 10, "R9 system source", v, 10);

    // R10 prescaled source
    wr(6'h24, 32'h0200);
    run(40, 1); run(1, 0);
    rd(6'h20, v); chk(v == 5, "R10 divide by 8", v, 5);

    // R11 halt
    wr(6'h24, 32'h0001);
    run(10, 1);
    rd(6'h20, v); chk(v == 0, "R11 halted", v, 0);
    wr(6'h20, 32'h55);
    run(3, 1);
    rd(6'h20, v); chk(v == 16'h55, "R11 write while halted", v, 16'h55);

    // random traffic, checked every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      int op, rs;
      slot();
      op = $urandom % 4;
      rs = $urandom % 4;
      bus_addr = {2'($urandom % 4), 2'(rs), 2'b00};
      bus_en = (op != 0);
      bus_we = (op == 1);
      if (rs == 0)      bus_wdata = ($urandom % 2) ? 32'hFFF0 + ($urandom % 16) : $urandom % 16;
      else if (rs == 2) bus_wdata = $urandom % 8;
      else              bus_wdata = $urandom;
      sys_tick = $urandom % 2; pix_tick = $urandom % 2; line_tick = $urandom % 2;
    end
    run(3, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule